// File: doc/BRIEF.md
# Timer and Interrupt Register Block

A byte-wide register file for a host processor that pairs two 8-bit general ports with two 16-bit down-counters and a seven-source interrupt controller. The host reaches sixteen byte registers through a synchronous bus. A write strobe updates a register at the clock edge. A read strobe returns the selected byte on `rdata` one clock later. Several accesses have side effects: some reads acknowledge interrupt flags, and writing a timer's high byte starts that timer.

The two counters decrement on a shared count-enable input `tick`. The first counter has a 16-bit reload latch and can run one-shot or free-running. The second has an 8-bit low latch and always runs one-shot. A counter raises its flag when it steps past zero. A pulse on `sr_evt` from external serial logic raises the shift flag. `irq` is high while any flag is set together with its enable bit.

Top module: `vreg_top`

## Requirements
- R1: The register index is `addr[12:9]`, and the remaining address bits are ignored. The indices are: 0 port B, 1 port A, 2 direction B, 3 direction A, 4 counter-1 low, 5 counter-1 high, 6 latch-1 low, 7 latch-1 high, 8 counter-2 low, 9 counter-2 high, 10 shift data, 11 auxiliary control, 12 peripheral control, 13 flags, 14 enables, 15 port A alias. `rdata` is registered. It shows the selected register's value from before the edge at which `rd_en` was sampled.
- R2: After reset, every register, latch, counter, flag and enable bit is zero, `rdata` is zero and `irq` is low.
- R3: A read of a port returns `(out & dir) | (pin & ~dir)`. Indices 1 and 15 both access port A. The `*_out` ports carry the output register and the `*_oe` ports carry the direction register.
- R4: A write to index 4 or index 6 replaces only the low byte of latch 1 and leaves counter 1 unchanged.
- R5: A write to index 5 sets the latch-1 high byte, loads counter 1 with {written byte, latch-1 low byte} and clears flag bit 6. A write to index 7 sets the latch-1 high byte and clears flag bit 6 without changing counter 1.
- R6: A read of index 4 returns counter-1 bits [7:0] and clears flag bit 6. A read of index 5 returns bits [15:8] and leaves the flag unchanged. Indices 6 and 7 return the latch-1 bytes.
- R7: A write to index 8 stores the byte in the counter-2 low latch and loads counter 2 with {8'h00, byte}. A write to index 9 loads counter 2 with {byte, low latch}.
- R8: A read of index 8 returns counter-2 bits [7:0] and clears flag bit 5. A read of index 9 returns bits [15:8].
- R9: Each cycle with `tick` high, each counter decrements by one. A load written to that counter in the same cycle wins instead. When counter 1 steps from zero:
  - with auxiliary bit 6 = 1, it reloads from latch 1 and sets flag bit 6 every time;
  - otherwise it wraps to 16'hFFFF and sets flag bit 6 only on the first such step after a load.

  Counter 2 always wraps and sets flag bit 5 only on the first step from zero after a load.
- R10: Index 10 is a plain byte register. Reading it clears flag bits 4:2. A pulse on `sr_evt` sets flag bit 2.
- R11: A read of index 13 returns the flags in bits [6:0], with bit 7 = 1 when any flag and its enable are both set. Writing index 13 clears each flag whose written bit is 1. When a set event and a clear fall in the same cycle, the flag ends set.
- R12: A write to index 14 with bit 7 = 1 ORs bits [6:0] into the enable mask. With bit 7 = 0 it clears the mask bits written as 1. A read returns the mask with bit 7 = 1.
- R13: `irq` is high exactly when some flag bit and its enable bit are both 1.
- R14: Indices 11 and 12 read back the last byte written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 13 | Bus address; bits [12:9] select the register |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| tick | input | 1 | Count enable for both counters |
| sr_evt | input | 1 | Shift-complete pulse from serial logic |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A direction (1 = drive) |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B direction (1 = drive) |
| irq | output | 1 | Interrupt request |

## Verification
The bench first checks that reading the counter-1 high byte leaves the flag set. A design that cleared the flag on either byte would make the second flag read show zero. It then checks the latch-high write against the counter-high write: a design that restarted the count on the latch write would read back the latch value instead of 16'hFFFF. The one-shot case runs a full 65,536-tick wrap after an acknowledged underflow. A design that rearmed itself would raise the flag a second time there. Two collisions are checked: a flag clear landing on an underflow, and a counter load landing on a tick. A wrong priority would lose the event or return the load value minus one.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

    localparam int BYTE_W   = 8;
    localparam int FLAG_N   = BYTE_W - 1;

    localparam int FLG_SHIFT = 2;
    localparam int FLG_SCLK  = 3;
    localparam int FLG_SDAT  = 4;
    localparam int FLG_CT2   = 5;
    localparam int FLG_CT1   = 6;

    localparam int AUX_FREE_RUN = 6;

    typedef enum logic [3:0] {
        RG_PB      = 4'd0,
        RG_PA      = 4'd1,
        RG_DIRB    = 4'd2,
        RG_DIRA    = 4'd3,
        RG_C1_LO   = 4'd4,
        RG_C1_HI   = 4'd5,
        RG_L1_LO   = 4'd6,
        RG_L1_HI   = 4'd7,
        RG_C2_LO   = 4'd8,
        RG_C2_HI   = 4'd9,
        RG_SHIFT   = 4'd10,
        RG_AUX     = 4'd11,
        RG_PERI    = 4'd12,
        RG_FLAGS   = 4'd13,
        RG_ENABLE  = 4'd14,
        RG_PA_RAW  = 4'd15
    } reg_idx_e;

endpackage

// File: rtl/vreg_port.sv
module vreg_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_out,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] out_o,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] rd_val
);

    typedef struct packed {
        logic [W-1:0] outv;
        logic [W-1:0] dir;
    } port_t;

    port_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_out) st_d.outv = wdata;
        if (wr_dir) st_d.dir  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o  = st_q.outv;
    assign oe_o   = st_q.dir;
    assign rd_val = (st_q.outv & st_q.dir) | (pin_in & ~st_q.dir);

    // R3: a direction write takes effect on the next cycle
    a_r3_dir_update: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (oe_o == $past(wdata)));

endmodule

// File: rtl/vreg_timer.sv
module vreg_timer #(
    parameter int DW         = 8,
    parameter bit WIDE_LATCH = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           free_run,
    input  logic           ld_lo_cnt,
    input  logic           ld_hi_cnt,
    input  logic           ld_lo_lat,
    input  logic           ld_hi_lat,
    input  logic [DW-1:0]  wdata,
    output logic [2*DW-1:0] count_o,
    output logic [2*DW-1:0] latch_o,
    output logic           uf_o
);

    localparam int TW = 2 * DW;

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic [TW-1:0] lat;
        logic          armed;
    } tmr_t;

    tmr_t st_d, st_q;

    generate
        if (WIDE_LATCH) begin : g_reload
            always_comb begin
                st_d = st_q;
                uf_o = 1'b0;
                if (ld_lo_cnt || ld_lo_lat) st_d.lat[DW-1:0]  = wdata;
                if (ld_hi_cnt || ld_hi_lat) st_d.lat[TW-1:DW] = wdata;
                if (ld_hi_cnt) begin
                    st_d.cnt   = {wdata, st_q.lat[DW-1:0]};
                    st_d.armed = 1'b1;
                end else if (tick) begin
                    if (st_q.cnt == '0) begin
                        uf_o = st_q.armed | free_run;
                        if (free_run) begin
                            st_d.cnt = st_q.lat;
                        end else begin
                            st_d.cnt   = '1;
                            st_d.armed = 1'b0;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
        end else begin : g_oneshot
            logic unused_oneshot_in;
            assign unused_oneshot_in = free_run ^ ld_lo_lat ^ ld_hi_lat;

            always_comb begin
                st_d = st_q;
                uf_o = 1'b0;
                if (ld_lo_cnt) begin
                    st_d.lat[DW-1:0] = wdata;
                    st_d.cnt         = {{DW{1'b0}}, wdata};
                    st_d.armed       = 1'b1;
                end else if (ld_hi_cnt) begin
                    st_d.cnt   = {wdata, st_q.lat[DW-1:0]};
                    st_d.armed = 1'b1;
                end else if (tick) begin
                    if (st_q.cnt == '0) begin
                        uf_o       = st_q.armed;
                        st_d.cnt   = '1;
                        st_d.armed = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign latch_o = st_q.lat;

    // R9: an idle tick on a nonzero count steps it down by one
    a_r9_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_lo_cnt && !ld_hi_cnt && st_q.cnt != '0)
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R5 and R7: a high-byte counter write loads {byte, low latch}
    a_r5_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi_cnt |=> (st_q.cnt == {$past(wdata), $past(st_q.lat[DW-1:0])}));

endmodule

// File: rtl/vreg_irq.sv
module vreg_irq #(
    parameter int DW = 8,
    parameter int NF = DW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    input  logic          ier_we,
    input  logic [DW-1:0] wdata,
    output logic [NF-1:0] flags_o,
    output logic [NF-1:0] mask_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [NF-1:0] flags;
        logic [NF-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
        if (ier_we) begin
            if (wdata[DW-1]) st_d.mask = st_q.mask | wdata[NF-1:0];
            else             st_d.mask = st_q.mask & ~wdata[NF-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign mask_o  = st_q.mask;
    assign irq_o   = |(st_q.flags & st_q.mask);

    // R11: an event beats a clear that lands in the same cycle
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((st_q.flags & $past(set_i)) == $past(set_i)));

    // R12: set form of an enable write
    a_r12_ier_set: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_we && wdata[DW-1])
        |=> ((st_q.mask & $past(wdata[NF-1:0])) == $past(wdata[NF-1:0])));

    // R12: clear form of an enable write
    a_r12_ier_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_we && !wdata[DW-1])
        |=> ((st_q.mask & $past(wdata[NF-1:0])) == '0));

endmodule

// File: rtl/vreg_top.sv
module vreg_top
    import vreg_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int SEL_LSB = 9,
    parameter int DW      = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DW-1:0]     rdata,
    input  logic              tick,
    input  logic              sr_evt,
    input  logic [DW-1:0]     pa_in,
    output logic [DW-1:0]     pa_out,
    output logic [DW-1:0]     pa_oe,
    input  logic [DW-1:0]     pb_in,
    output logic [DW-1:0]     pb_out,
    output logic [DW-1:0]     pb_oe,
    output logic              irq
);

    localparam int SEL_W  = 4;
    localparam int NF     = DW - 1;
    localparam int TW     = 2 * DW;
    localparam int NPORT  = 2;

    reg_idx_e sel;
    assign sel = reg_idx_e'(addr[SEL_LSB +: SEL_W]);

    logic unused_addr;
    generate
        if (ADDR_W > SEL_LSB + SEL_W) begin : g_addr_hi
            assign unused_addr = ^{addr[SEL_LSB-1:0], addr[ADDR_W-1:SEL_LSB+SEL_W]};
        end else begin : g_addr_fit
            assign unused_addr = ^addr[SEL_LSB-1:0];
        end
    endgenerate

    // ---------------- ports (index 0 = B, index 1 = A) ----------------
    logic [DW-1:0] prt_pin  [NPORT];
    logic [DW-1:0] prt_out  [NPORT];
    logic [DW-1:0] prt_oe   [NPORT];
    logic [DW-1:0] prt_rd   [NPORT];
    logic          prt_wo   [NPORT];
    logic          prt_wd   [NPORT];

    assign prt_pin[0] = pb_in;
    assign prt_pin[1] = pa_in;
    assign prt_wo[0]  = wr_en && (sel == RG_PB);
    assign prt_wo[1]  = wr_en && (sel == RG_PA || sel == RG_PA_RAW);
    assign prt_wd[0]  = wr_en && (sel == RG_DIRB);
    assign prt_wd[1]  = wr_en && (sel == RG_DIRA);

    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            vreg_port #(.W(DW)) u_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_out (prt_wo[g]),
                .wr_dir (prt_wd[g]),
                .wdata  (wdata),
                .pin_in (prt_pin[g]),
                .out_o  (prt_out[g]),
                .oe_o   (prt_oe[g]),
                .rd_val (prt_rd[g])
            );
        end
    endgenerate

    assign pb_out = prt_out[0];
    assign pb_oe  = prt_oe[0];
    assign pa_out = prt_out[1];
    assign pa_oe  = prt_oe[1];

    // ---------------- local registers ----------------
    typedef struct packed {
        logic [DW-1:0] aux;
        logic [DW-1:0] peri;
        logic [DW-1:0] shd;
        logic [DW-1:0] rdata;
    } top_t;

    top_t st_d, st_q;

    // ---------------- counters ----------------
    logic [TW-1:0] c1_cnt, c1_lat, c2_cnt, unused_c2_lat;
    logic          c1_uf, c2_uf;

    vreg_timer #(.DW(DW), .WIDE_LATCH(1'b1)) u_ct1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .free_run  (st_q.aux[AUX_FREE_RUN]),
        .ld_lo_cnt (wr_en && sel == RG_C1_LO),
        .ld_hi_cnt (wr_en && sel == RG_C1_HI),
        .ld_lo_lat (wr_en && sel == RG_L1_LO),
        .ld_hi_lat (wr_en && sel == RG_L1_HI),
        .wdata     (wdata),
        .count_o   (c1_cnt),
        .latch_o   (c1_lat),
        .uf_o      (c1_uf)
    );

    vreg_timer #(.DW(DW), .WIDE_LATCH(1'b0)) u_ct2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .free_run  (1'b0),
        .ld_lo_cnt (wr_en && sel == RG_C2_LO),
        .ld_hi_cnt (wr_en && sel == RG_C2_HI),
        .ld_lo_lat (1'b0),
        .ld_hi_lat (1'b0),
        .wdata     (wdata),
        .count_o   (c2_cnt),
        .latch_o   (unused_c2_lat),
        .uf_o      (c2_uf)
    );

    // ---------------- interrupt flags and enables ----------------
    logic [NF-1:0] flg_set, flg_clr, flags, mask;

    always_comb begin
        flg_set            = '0;
        flg_set[FLG_CT1]   = c1_uf;
        flg_set[FLG_CT2]   = c2_uf;
        flg_set[FLG_SHIFT] = sr_evt;

        flg_clr = '0;
        if (wr_en && sel == RG_FLAGS)                      flg_clr = wdata[NF-1:0];
        if (wr_en && (sel == RG_C1_HI || sel == RG_L1_HI)) flg_clr[FLG_CT1] = 1'b1;
        if (rd_en && sel == RG_C1_LO)                      flg_clr[FLG_CT1] = 1'b1;
        if (rd_en && sel == RG_C2_LO)                      flg_clr[FLG_CT2] = 1'b1;
        if (rd_en && sel == RG_SHIFT) begin
            flg_clr[FLG_SHIFT] = 1'b1;
            flg_clr[FLG_SCLK]  = 1'b1;
            flg_clr[FLG_SDAT]  = 1'b1;
        end
    end

    vreg_irq #(.DW(DW), .NF(NF)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flg_set),
        .clr_i   (flg_clr),
        .ier_we  (wr_en && sel == RG_ENABLE),
        .wdata   (wdata),
        .flags_o (flags),
        .mask_o  (mask),
        .irq_o   (irq)
    );

    // ---------------- next state and read mux ----------------
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                RG_AUX:   st_d.aux  = wdata;
                RG_PERI:  st_d.peri = wdata;
                RG_SHIFT: st_d.shd  = wdata;
                default:  ;
            endcase
        end
        if (rd_en) begin
            case (sel)
                RG_PB:     st_d.rdata = prt_rd[0];
                RG_PA:     st_d.rdata = prt_rd[1];
                RG_DIRB:   st_d.rdata = prt_oe[0];
                RG_DIRA:   st_d.rdata = prt_oe[1];
                RG_C1_LO:  st_d.rdata = c1_cnt[DW-1:0];
                RG_C1_HI:  st_d.rdata = c1_cnt[TW-1:DW];
                RG_L1_LO:  st_d.rdata = c1_lat[DW-1:0];
                RG_L1_HI:  st_d.rdata = c1_lat[TW-1:DW];
                RG_C2_LO:  st_d.rdata = c2_cnt[DW-1:0];
                RG_C2_HI:  st_d.rdata = c2_cnt[TW-1:DW];
                RG_SHIFT:  st_d.rdata = st_q.shd;
                RG_AUX:    st_d.rdata = st_q.aux;
                RG_PERI:   st_d.rdata = st_q.peri;
                RG_FLAGS:  st_d.rdata = {(|(flags & mask)), flags};
                RG_ENABLE: st_d.rdata = {1'b1, mask};
                default:   st_d.rdata = prt_rd[1];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    // R12: an enable read always shows bit 7 set
    a_r12_ier_read_top: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == RG_ENABLE) |=> rdata[DW-1]);

    // R8: a counter-2 low read leaves flag 5 clear unless an underflow lands
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == RG_C2_LO && !c2_uf) |=> !flags[FLG_CT2]);

endmodule

// File: tb/vreg_top_bench.sv
module vreg_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic        tick = 1'b0;
    logic        sr_evt = 1'b0;
    logic [7:0]  pa_in = '0;
    logic [7:0]  pa_out, pa_oe;
    logic [7:0]  pb_in = '0;
    logic [7:0]  pb_out, pb_oe;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vreg_top u_vreg_top (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wdata  (wdata),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .rdata  (rdata),
        .tick   (tick),
        .sr_evt (sr_evt),
        .pa_in  (pa_in),
        .pa_out (pa_out),
        .pa_oe  (pa_oe),
        .pb_in  (pb_in),
        .pb_out (pb_out),
        .pb_oe  (pb_oe),
        .irq    (irq)
    );

    // scoreboard
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata got %02h expected %02h", t, rdata, e);
            end
        end
    end

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string t);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", t, got, exp);
        end
    endtask

    task automatic op(input logic w, input logic r, input logic [3:0] idx,
                      input logic [7:0] d, input logic tk);
        wr_en = w;
        rd_en = r;
        addr  = {idx, 9'h1A5};
        wdata = d;
        tick  = tk;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        tick  = 1'b0;
        addr  = {4'hF, 9'h05A};
    endtask

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        op(1'b1, 1'b0, idx, d, 1'b0);
    endtask

    task automatic rd(input logic [3:0] idx, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        op(1'b0, 1'b1, idx, 8'h00, 1'b0);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_sr();
        sr_evt = 1'b1;
        @(negedge clk);
        sr_evt = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        chk({7'd0, irq}, 8'h00, "R2 irq");
        chk(pa_oe, 8'h00, "R2 pa_oe");
        chk(pb_out, 8'h00, "R2 pb_out");
        chk(rdata, 8'h00, "R2 rdata");
        rd(4'd14, 8'h80, "R2 enable mask zero");
        rd(4'd13, 8'h00, "R2 flags zero");
        rd(4'd4,  8'h00, "R2 counter1 zero");
        rd(4'd11, 8'h00, "R2 aux zero");

        // R3 ports, R1 decode
        pa_in = 8'h3C;
        pb_in = 8'hC0;
        wr(4'd3, 8'hF0);
        wr(4'd1, 8'hA5);
        rd(4'd1,  8'hAC, "R3 port A mixed");
        rd(4'd15, 8'hAC, "R1 R3 port A alias");
        chk(pa_out, 8'hA5, "R3 pa_out");
        chk(pa_oe, 8'hF0, "R3 pa_oe");
        wr(4'd15, 8'h5A);
        chk(pa_out, 8'h5A, "R3 alias write");
        wr(4'd2, 8'h0F);
        wr(4'd0, 8'h33);
        rd(4'd0, 8'hC3, "R3 port B mixed");
        rd(4'd2, 8'h0F, "R1 dir B");

        // R14
        wr(4'd11, 8'h00);
        wr(4'd12, 8'h7E);
        rd(4'd12, 8'h7E, "R14 peripheral ctl");

        // R4 latch low writes leave counter alone
        wr(4'd4, 8'h05);
        rd(4'd6, 8'h05, "R4 latch low via 4");
        rd(4'd4, 8'h00, "R4 counter unchanged");
        wr(4'd6, 8'h03);
        rd(4'd6, 8'h03, "R4 latch low via 6");
        // R5 load
        wr(4'd5, 8'h00);
        rd(4'd5, 8'h00, "R6 counter1 high");
        rd(4'd4, 8'h03, "R5 counter1 loaded");

        // R12 set form
        wr(4'd14, 8'hE0);
        rd(4'd14, 8'hE0, "R12 set form");

        // R9 one-shot underflow
        ticks(3);
        rd(4'd4, 8'h00, "R9 counted to zero");
        chk({7'd0, irq}, 8'h00, "R9 no flag at zero");
        ticks(1);
        chk({7'd0, irq}, 8'h01, "R13 irq on timer1");
        rd(4'd13, 8'hC0, "R11 summary with flag 6");
        rd(4'd5,  8'hFF, "R6 high read after wrap");
        rd(4'd13, 8'hC0, "R6 high read keeps flag");
        rd(4'd4,  8'hFF, "R6 low read after wrap");
        rd(4'd13, 8'h00, "R6 low read clears flag");
        chk({7'd0, irq}, 8'h00, "R13 irq dropped");
        ticks(65536);
        rd(4'd13, 8'h00, "R9 one-shot flags once");
        rd(4'd4,  8'hFF, "R9 full wrap count");

        // R5 latch-high write: clear flag, no reload
        wr(4'd5, 8'h00);
        ticks(4);
        chk({7'd0, irq}, 8'h01, "R9 flag after reload");
        wr(4'd7, 8'h12);
        rd(4'd13, 8'h00, "R5 latch high clears flag");
        rd(4'd5,  8'hFF, "R5 latch high no reload");
        rd(4'd7,  8'h12, "R6 latch high byte");

        // R9 free-run
        wr(4'd11, 8'h40);
        rd(4'd11, 8'h40, "R14 aux");
        wr(4'd6, 8'h02);
        wr(4'd7, 8'h00);
        wr(4'd5, 8'h00);
        ticks(1);
        rd(4'd4, 8'h01, "R9 decrement");
        ticks(2);
        rd(4'd13, 8'hC0, "R9 free-run flag");
        rd(4'd4,  8'h02, "R9 free-run reload");
        rd(4'd13, 8'h00, "R6 low read clear");
        ticks(3);
        rd(4'd13, 8'hC0, "R9 free-run repeats");

        // R11 clear by write; set wins over clear
        wr(4'd13, 8'h40);
        rd(4'd13, 8'h00, "R11 write clears");
        ticks(2);
        op(1'b1, 1'b0, 4'd13, 8'h40, 1'b1);
        rd(4'd13, 8'hC0, "R11 set beats clear");
        // R9 load beats tick
        op(1'b1, 1'b0, 4'd5, 8'h00, 1'b1);
        rd(4'd4,  8'h02, "R9 load beats tick");
        rd(4'd13, 8'h00, "R5 counter high clears flag");

        // R7 R8 timer 2
        wr(4'd6, 8'hFF);
        wr(4'd5, 8'hFF);
        wr(4'd11, 8'h00);
        wr(4'd8, 8'h04);
        rd(4'd9, 8'h00, "R7 counter2 high after low write");
        rd(4'd8, 8'h04, "R7 counter2 low load");
        ticks(5);
        chk({7'd0, irq}, 8'h01, "R13 irq on timer2");
        rd(4'd13, 8'hA0, "R9 timer2 flag");
        rd(4'd8,  8'hFF, "R8 counter2 wrap");
        rd(4'd13, 8'h00, "R8 low read clears");
        wr(4'd9, 8'h01);
        rd(4'd9, 8'h01, "R7 high byte load");
        rd(4'd8, 8'h04, "R7 low latch reused");

        // R12 clear form
        wr(4'd14, 8'h20);
        rd(4'd14, 8'hC0, "R12 clear form");
        wr(4'd14, 8'h84);
        rd(4'd14, 8'hC4, "R12 set bit 2");

        // R10 shift data
        wr(4'd10, 8'h9C);
        rd(4'd10, 8'h9C, "R10 shift data");
        pulse_sr();
        chk({7'd0, irq}, 8'h01, "R10 shift event irq");
        rd(4'd13, 8'h84, "R10 shift flag");
        rd(4'd10, 8'h9C, "R10 read again");
        rd(4'd13, 8'h00, "R10 read clears shift flags");
        chk({7'd0, irq}, 8'h00, "R13 irq low");

        // R11 no summary without enable
        wr(4'd14, 8'h04);
        pulse_sr();
        rd(4'd13, 8'h04, "R11 flag without enable");
        chk({7'd0, irq}, 8'h00, "R13 masked flag");
        wr(4'd13, 8'hFF);
        rd(4'd13, 8'h00, "R11 clear all");

        @(negedge clk);
        chk(8'(exp_q.size()), 8'h00, "R1 all reads returned");
        finish_run();
    end

endmodule